// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block produces the timing strobes of a multiplexed external memory bus: the address latch pulse, the program fetch strobe (active low), the data read and write strobes (active low) and a two-bit select that tells the port logic whether the shared lines carry an address or data. It runs from the oscillator clock. A machine cycle lasts twelve oscillator clocks, and a free-running phase counter splits it into phases 0 to 11.

The control logic tells the block what kind of cycle is next: an external data read or write, a table read from program space, external execution, the address-latch silencing bit, idle and power-down. These inputs are sampled once, on the clock edge that ends a machine cycle. They set the strobe pattern for the whole of the following cycle, so a change in the middle of a cycle cannot break a pulse apart. Each output comes from a register, one clock after the phase that it represents.

Top module: `bus_strobe_seq`

## Requirements
- R1: Reset is asynchronous and active low. While it is held, ale_o=0, psen_n_o=1, rd_n_o=1, wr_n_o=1 and ad_sel_o=00. The first machine cycle after reset uses all-zero cycle flags, whatever the inputs are.
- R2: Edge 1 is the first rising edge after reset is released. The inputs present at edge 12m (m≥1) control the outputs after edges 12m+1 to 12m+12, and the output after edge 12m+1+p shows phase p (0 to 11) of machine cycle m. Input changes at any other time have no effect.
- R3: In a cycle that is not forced, has no data access and has ALE enabled, ale_o is high in phases 0-1 and 6-7: two pulses, each two clocks wide.
- R4: In a data-access cycle (read or write), the second ALE pulse (phases 6-7) is skipped and psen_n_o stays high for the whole cycle.
- R5: When external execution or a table read is flagged and there is no data access, psen_n_o is low in phases 3-5 and 9-11.
- R6: For a data read, rd_n_o is low in phases 5-10, which starts three clocks after ALE falls. A write drives wr_n_o over the same phases. If both are flagged the cycle is a read, and rd_n_o and wr_n_o are never low together.
- R7: With the ALE-off bit set and external execution clear, ALE pulses only in cycles that have a data access or a table read. External execution overrides the bit.
- R8: In an idle cycle, ale_o=1, psen_n_o=1, rd_n_o=1, wr_n_o=1 and ad_sel_o=00 for all twelve phases.
- R9: In a power-down cycle, ale_o=0, psen_n_o=0, rd_n_o=1, wr_n_o=1 and ad_sel_o=00. Power-down takes priority over idle.
- R10: In a cycle that is not forced, ad_sel_o=01 while ale_o is high, ad_sel_o=10 while psen_n_o, rd_n_o or wr_n_o is low, and ad_sel_o=00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xdata_rd_i | input | 1 | Next cycle reads external data |
| xdata_wr_i | input | 1 | Next cycle writes external data |
| table_rd_i | input | 1 | Next cycle is a table read from program space |
| ext_exec_i | input | 1 | Code runs from external program memory |
| ale_off_i | input | 1 | Silence ALE outside data and table accesses |
| idle_i | input | 1 | Idle mode |
| pwrdn_i | input | 1 | Power-down mode |
| ale_o | output | 1 | Address latch enable |
| psen_n_o | output | 1 | Program fetch strobe, active low |
| rd_n_o | output | 1 | Data read strobe, active low |
| wr_n_o | output | 1 | Data write strobe, active low |
| ad_sel_o | output | 2 | Bus phase: 00 none, 01 address, 10 data |

## Verification
The flags set up for machine cycle m are captured on edge 12m. The twelve phases of that cycle appear one register later, on edges 12m+1 to 12m+12. For every machine cycle the driver places twelve expected items in a queue, worked out from the requirements. The monitor takes one item off the queue on each falling clock edge and compares it with all five outputs. Halfway through every cycle the driver inverts all inputs and restores proper values just before the next sampling edge, so any sampling outside the cycle boundary would show up as a mismatch.

// File: rtl/bss_pkg.sv
package bss_pkg;

    typedef enum logic [1:0] {
        AD_NONE = 2'b00,
        AD_ADDR = 2'b01,
        AD_DATA = 2'b10
    } ad_sel_e;

    // Per-machine-cycle control, captured at the cycle boundary
    typedef struct packed {
        logic ext_exec;
        logic ale_off;
        logic idle;
        logic pwrdn;
        logic xrd;
        logic xwr;
        logic tbl;
    } cyc_flags_t;

    typedef struct packed {
        logic    ale;
        logic    psen_n;
        logic    rd_n;
        logic    wr_n;
        ad_sel_e ad;
    } strobe_t;

    localparam strobe_t STROBE_RESET = '{
        ale:    1'b0,
        psen_n: 1'b1,
        rd_n:   1'b1,
        wr_n:   1'b1,
        ad:     AD_NONE
    };

endpackage

// File: rtl/bss_phase_ctr.sv
module bss_phase_ctr #(
    parameter int CYC_LEN = 12,
    parameter int PH_W    = $clog2(CYC_LEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] phase_o,
    output logic            wrap_o
);

    localparam logic [PH_W-1:0] LAST = PH_W'(CYC_LEN - 1);

    logic [PH_W-1:0] phase_d, phase_q;

    always_comb begin
        phase_d = (phase_q == LAST) ? '0 : phase_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end

    assign phase_o = phase_q;
    assign wrap_o  = (phase_q == LAST);

    // R2
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (phase_o == '0));

    // R2
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_o |=> (phase_o == $past(phase_o) + 1'b1));

endmodule

// File: rtl/bss_cycle_latch.sv
module bss_cycle_latch
    import bss_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wrap_i,
    input  cyc_flags_t flags_i,
    output cyc_flags_t flags_o
);

    cyc_flags_t flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (wrap_i) flags_d = flags_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags_o = flags_q;

    // R2
    hold_mid_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_i |=> (flags_o == $past(flags_o)));

endmodule

// File: rtl/bss_strobe_gen.sv
module bss_strobe_gen
    import bss_pkg::*;
#(
    parameter int CYC_LEN    = 12,
    parameter int PH_W       = $clog2(CYC_LEN),
    parameter int ALE_W      = 2,
    parameter int PSEN_START = 3,
    parameter int PSEN_W     = 3,
    parameter int RW_START   = 5,
    parameter int RW_W       = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] phase_i,
    input  cyc_flags_t      flags_i,
    output strobe_t         strobe_o
);

    localparam int HALF = CYC_LEN / 2;

    function automatic logic in_win(input logic [PH_W-1:0] ph,
                                    input int start, input int width);
        return (int'(ph) >= start) && (int'(ph) < start + width);
    endfunction

    strobe_t out_d, out_q;
    logic    acc, rd_eff, wr_eff, ale_en, fetch_en;

    always_comb begin
        out_d    = STROBE_RESET;
        acc      = flags_i.xrd | flags_i.xwr;
        rd_eff   = flags_i.xrd;
        wr_eff   = flags_i.xwr & ~flags_i.xrd;
        ale_en   = flags_i.ext_exec | ~flags_i.ale_off | acc | flags_i.tbl;
        fetch_en = (flags_i.ext_exec | flags_i.tbl) & ~acc;

        if (flags_i.pwrdn) begin
            out_d.ale    = 1'b0;
            out_d.psen_n = 1'b0;
        end else if (flags_i.idle) begin
            out_d.ale    = 1'b1;
            out_d.psen_n = 1'b1;
        end else begin
            out_d.ale = ale_en &
                        (in_win(phase_i, 0, ALE_W) |
                         (~acc & in_win(phase_i, HALF, ALE_W)));
            out_d.psen_n = ~(fetch_en &
                             (in_win(phase_i, PSEN_START, PSEN_W) |
                              in_win(phase_i, PSEN_START + HALF, PSEN_W)));
            out_d.rd_n = ~(rd_eff & in_win(phase_i, RW_START, RW_W));
            out_d.wr_n = ~(wr_eff & in_win(phase_i, RW_START, RW_W));
            if (out_d.ale)
                out_d.ad = AD_ADDR;
            else if (!out_d.psen_n || !out_d.rd_n || !out_d.wr_n)
                out_d.ad = AD_DATA;
            else
                out_d.ad = AD_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= STROBE_RESET;
        else        out_q <= out_d;
    end

    assign strobe_o = out_q;

    // R9
    pwrdn_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_i.pwrdn |=> (!out_q.ale && !out_q.psen_n && out_q.rd_n && out_q.wr_n));

    // R8
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_i.idle && !flags_i.pwrdn) |=> (out_q.ale && out_q.psen_n && out_q.rd_n && out_q.wr_n));

    // R3
    ale_two_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(out_q.ale) && !flags_i.idle && !flags_i.pwrdn) |=> out_q.ale);

    // R6
    rw_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!out_q.rd_n && !out_q.wr_n));

    // R4
    fetch_data_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!out_q.psen_n && (!out_q.rd_n || !out_q.wr_n)));

    // R6
    rd_after_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_q.rd_n) |-> ($past(out_q.ale, 4) && !$past(out_q.ale, 3)));

endmodule

// File: rtl/bus_strobe_seq.sv
module bus_strobe_seq
    import bss_pkg::*;
#(
    parameter int CYC_LEN    = 12,
    parameter int ALE_W      = 2,
    parameter int PSEN_START = 3,
    parameter int PSEN_W     = 3,
    parameter int RW_START   = 5,
    parameter int RW_W       = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       xdata_rd_i,
    input  logic       xdata_wr_i,
    input  logic       table_rd_i,
    input  logic       ext_exec_i,
    input  logic       ale_off_i,
    input  logic       idle_i,
    input  logic       pwrdn_i,
    output logic       ale_o,
    output logic       psen_n_o,
    output logic       rd_n_o,
    output logic       wr_n_o,
    output logic [1:0] ad_sel_o
);

    localparam int PH_W = $clog2(CYC_LEN);

    logic [PH_W-1:0] phase;
    logic            wrap;
    cyc_flags_t      flags_in, flags_cur;
    strobe_t         strobe;

    always_comb begin
        flags_in.ext_exec = ext_exec_i;
        flags_in.ale_off  = ale_off_i;
        flags_in.idle     = idle_i;
        flags_in.pwrdn    = pwrdn_i;
        flags_in.xrd      = xdata_rd_i;
        flags_in.xwr      = xdata_wr_i;
        flags_in.tbl      = table_rd_i;
    end

    bss_phase_ctr #(
        .CYC_LEN (CYC_LEN),
        .PH_W    (PH_W)
    ) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_o (phase),
        .wrap_o  (wrap)
    );

    bss_cycle_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wrap_i  (wrap),
        .flags_i (flags_in),
        .flags_o (flags_cur)
    );

    bss_strobe_gen #(
        .CYC_LEN    (CYC_LEN),
        .PH_W       (PH_W),
        .ALE_W      (ALE_W),
        .PSEN_START (PSEN_START),
        .PSEN_W     (PSEN_W),
        .RW_START   (RW_START),
        .RW_W       (RW_W)
    ) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_i  (phase),
        .flags_i  (flags_cur),
        .strobe_o (strobe)
    );

    assign ale_o    = strobe.ale;
    assign psen_n_o = strobe.psen_n;
    assign rd_n_o   = strobe.rd_n;
    assign wr_n_o   = strobe.wr_n;
    assign ad_sel_o = strobe.ad;

    // R10
    ad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_sel_o == 2'b01) |-> ale_o);

    // R10
    ad_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_sel_o == 2'b10) |-> (!ale_o && (!psen_n_o || !rd_n_o || !wr_n_o)));

endmodule

// File: tb/tb_bus_strobe_seq.sv
module tb_bus_strobe_seq;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xdata_rd = 1'b0, xdata_wr = 1'b0, table_rd = 1'b0;
    logic ext_exec = 1'b0, ale_off = 1'b0, idle = 1'b0, pwrdn = 1'b0;
    logic ale, psen_n, rd_n, wr_n;
    logic [1:0] ad_sel;

    always #4 clk = ~clk;

    bus_strobe_seq dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .xdata_rd_i (xdata_rd),
        .xdata_wr_i (xdata_wr),
        .table_rd_i (table_rd),
        .ext_exec_i (ext_exec),
        .ale_off_i  (ale_off),
        .idle_i     (idle),
        .pwrdn_i    (pwrdn),
        .ale_o      (ale),
        .psen_n_o   (psen_n),
        .rd_n_o     (rd_n),
        .wr_n_o     (wr_n),
        .ad_sel_o   (ad_sel)
    );

    typedef struct {
        logic       ale;
        logic       psen_n;
        logic       rd_n;
        logic       wr_n;
        logic [1:0] ad;
        string      tag;
        int         ph;
    } exp_t;

    exp_t q[$];
    int   errors = 0;
    int   checks = 0;
    bit   mon_en = 1'b0;
    bit   done   = 1'b0;

    function automatic exp_t model(int p, bit ext, bit off, bit idl, bit pd,
                                   bit rd, bit wr, bit tbl, string tag);
        exp_t e;
        bit acc, wre, ale_ok;
        acc = rd | wr;
        wre = wr & !rd;
        e.ale = 1'b0; e.psen_n = 1'b1; e.rd_n = 1'b1; e.wr_n = 1'b1; e.ad = 2'b00;
        e.tag = tag; e.ph = p;
        if (pd) begin
            e.psen_n = 1'b0;
        end else if (idl) begin
            e.ale = 1'b1;
        end else begin
            ale_ok = ext | !off | acc | tbl;
            if (ale_ok && (p == 0 || p == 1 || (!acc && (p == 6 || p == 7)))) e.ale = 1'b1;
            if ((ext || tbl) && !acc && ((p >= 3 && p <= 5) || p >= 9)) e.psen_n = 1'b0;
            if (rd && p >= 5 && p <= 10) e.rd_n = 1'b0;
            if (wre && p >= 5 && p <= 10) e.wr_n = 1'b0;
            if (e.ale) e.ad = 2'b01;
            else if (!e.psen_n || !e.rd_n || !e.wr_n) e.ad = 2'b10;
        end
        return e;
    endfunction

    task automatic push_cycle(bit ext, bit off, bit idl, bit pd,
                              bit rd, bit wr, bit tbl, string tag);
        for (int p = 0; p < 12; p++) q.push_back(model(p, ext, off, idl, pd, rd, wr, tbl, tag));
    endtask

    // Called at the falling edge after edge 12m-1; returns at the one after 12m+11
    task automatic run_cycle(bit ext, bit off, bit idl, bit pd,
                             bit rd, bit wr, bit tbl, string tag);
        ext_exec = ext; ale_off = off; idle = idl; pwrdn = pd;
        xdata_rd = rd; xdata_wr = wr; table_rd = tbl;
        push_cycle(ext, off, idl, pd, rd, wr, tbl, tag);
        repeat (5) @(negedge clk);
        ext_exec = !ext; ale_off = !off; idle = !idl; pwrdn = !pd;
        xdata_rd = !rd; xdata_wr = !wr; table_rd = !tbl;
        repeat (7) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (mon_en) begin
            if (q.size() == 0) begin
                errors++; checks++;
                $display("FAIL R2 output arrived with no expected item queued");
            end else begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (ale !== e.ale || psen_n !== e.psen_n || rd_n !== e.rd_n ||
                    wr_n !== e.wr_n || ad_sel !== e.ad) begin
                    errors++;
                    $display("FAIL %s phase %0d: ale=%b psen_n=%b rd_n=%b wr_n=%b ad=%b expected ale=%b psen_n=%b rd_n=%b wr_n=%b ad=%b",
                             e.tag, e.ph, ale, psen_n, rd_n, wr_n, ad_sel,
                             e.ale, e.psen_n, e.rd_n, e.wr_n, e.ad);
                end
            end
        end
    end

    initial begin
        repeat (4000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // Inputs that would change the first cycle if they were not ignored
        ext_exec = 1'b1; xdata_rd = 1'b1; ale_off = 1'b1; table_rd = 1'b1;
        repeat (3) @(negedge clk);
        checks++;
        if (ale !== 1'b0 || psen_n !== 1'b1 || rd_n !== 1'b1 || wr_n !== 1'b1 || ad_sel !== 2'b00) begin
            errors++;
            $display("FAIL R1 reset: ale=%b psen_n=%b rd_n=%b wr_n=%b ad=%b expected ale=0 psen_n=1 rd_n=1 wr_n=1 ad=00",
                     ale, psen_n, rd_n, wr_n, ad_sel);
        end
        // Cycle 0 runs on the reset flag values
        push_cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1,R2");
        rst_n = 1'b1;
        @(posedge clk);
        #1 mon_en = 1'b1;
        repeat (11) @(negedge clk);

        //          ext   off   idle  pd    rd    wr    tbl
        run_cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3,R5,R10");
        run_cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R4,R6");
        run_cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R4,R6");
        run_cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
        run_cycle(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
        run_cycle(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R7,R5");
        run_cycle(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R7,R6");
        run_cycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
        run_cycle(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
        run_cycle(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R9");
        run_cycle(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R9");
        run_cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R6");
        run_cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3,R5");

        @(negedge clk);
        #1 mon_en = 1'b0;
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R2 leftover expected items: %0d expected 0", q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule